// File: doc/BRIEF.md
# One-time-programmable memory debug read port

This block sits between an external debug host and a one-time-programmable code memory. The host reaches it through a small register bus made of a select code, read and write strobes, and a byte of write and read data. Before any memory access the host must hold the processor core in reset through a device-control register, and then open a read session through a memory-control register. It loads a 16-bit address into a high/low register pair and reads bytes from a data register. Each accepted data read returns the byte at the current address and advances the address by one. The address wraps from 0xFFFF to 0x0000.

A security byte from the memory gates all access. A zero anywhere in its low nibble blocks every read of code memory through the port. A zero anywhere in its high nibble marks code memory as write-protected. Programmed OTP bits cannot return to one, so a lock, once seen, is kept until the next block reset even if the byte later reads as all ones. Blocked reads and reads outside a session return zero, leave the address unchanged and set a sticky error flag. That flag is cleared when a new read session opens.

Top module: `otp_dbg_port`

## Requirements
- R1: After reset the core hold, the read session, the error flag and the address are all zero, and the status register reads 0x00 while the security byte is 0xFF.
- R2: Writing 0x04 to the device-control register (select 0) sets the core hold: `core_rst` goes high and status bit 4 reads 1.
- R3: The core hold clears only when 0x02 is written to the device-control register and the very next device-control write is 0x00. Clearing the hold also closes the read session. A 0x00 write that does not directly follow 0x02 leaves the hold set.
- R4: Writing 0x00 to the memory-control register (select 1) while the core hold is set opens a read session (status bit 3) and clears the error flag (status bit 0). The same write without the core hold has no effect.
- R5: A session closes only when 0x40 is written to the memory-control register and the next memory-control write is 0x00. A 0x40 alone leaves the session open.
- R6: A read of the data register (select 4) in an open, unlocked session returns the memory byte at the current address and then increments the address by one, wrapping from 0xFFFF to 0x0000.
- R7: When any of bits 7..4 of the security byte is 0, status bit 2 (write lock) reads 1. Otherwise it reads 0.
- R8: When any of bits 3..0 of the security byte is 0, status bit 1 (read lock) reads 1. Data reads then return 0x00, set the error flag and leave the address unchanged.
- R9: A read or write lock, once observed, stays reported and enforced until reset, even if the security byte returns to 0xFF.
- R10: A data read with no open session returns 0x00, sets the error flag and leaves the address unchanged.
- R11: The address high byte (select 2) and low byte (select 3) can each be written and read back. `mem_addr` presents the full address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 3 | Register select: 0 device control, 1 memory control, 2 address high, 3 address low, 4 data, 5 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, zero otherwise |
| mem_addr | output | 16 | Current memory address |
| mem_rdata | input | 8 | Byte at mem_addr, combinational from the memory |
| sec_byte | input | 8 | Security byte from the memory |
| core_rst | output | 1 | Core reset hold |

## Verification
A wrong session or hold bit shows up at once in the status register and in `core_rst`. It also shows up on the next data read, which either returns real data where zero was expected or the reverse. A wrong address, a missed increment or a missed wrap corrupts every following data byte, and the address readback exposes it in the next access. A lock that drops too early gives non-zero data on the first blocked read. All 256 security byte values are swept, each against a fresh reset.

// File: rtl/otp_dbg_port.sv
module otp_dbg_port #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] sec_byte,
  output logic          core_rst
);
  localparam int NB = DW / 2;
  localparam logic [2:0] S_DEV = 3'd0, S_MEM = 3'd1, S_AH = 3'd2,
                         S_AL = 3'd3, S_DAT = 3'd4, S_STA = 3'd5;
  localparam logic [DW-1:0] C_HOLD = DW'(8'h04), C_REL = DW'(8'h02),
                            C_ZERO = '0, C_EXIT = DW'(8'h40);

  logic hold, rel_pend, rd_mode, exit_pend, err, rlk_q, wlk_q;
  logic [AW-1:0] addr;
  logic rd_lock, wr_lock, data_rd, rd_ok;
  logic wr_dev, wr_mem;

  assign rd_lock = rlk_q | ~&sec_byte[NB-1:0];
  assign wr_lock = wlk_q | ~&sec_byte[DW-1:NB];
  assign wr_dev  = bus_wr && bus_sel == S_DEV;
  assign wr_mem  = bus_wr && bus_sel == S_MEM;
  assign data_rd = bus_rd && bus_sel == S_DAT;
  assign rd_ok   = data_rd && rd_mode && hold && !rd_lock;
  assign mem_addr = addr;
  assign core_rst = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0; rel_pend <= 1'b0; rd_mode <= 1'b0; exit_pend <= 1'b0;
      err <= 1'b0; rlk_q <= 1'b0; wlk_q <= 1'b0; addr <= '0;
    end else begin
      rlk_q <= rd_lock;
      wlk_q <= wr_lock;
      if (wr_dev) begin
        if (bus_wdata == C_HOLD) begin
          hold <= 1'b1; rel_pend <= 1'b0;
        end else if (bus_wdata == C_REL) begin
          rel_pend <= 1'b1;
        end else if (bus_wdata == C_ZERO && rel_pend) begin
          hold <= 1'b0; rd_mode <= 1'b0; exit_pend <= 1'b0; rel_pend <= 1'b0;
        end else begin
          rel_pend <= 1'b0;
        end
      end
      if (wr_mem && hold) begin
        if (bus_wdata == C_ZERO) begin
          if (exit_pend) begin
            rd_mode <= 1'b0; exit_pend <= 1'b0;
          end else begin
            rd_mode <= 1'b1; err <= 1'b0;
          end
        end else begin
          exit_pend <= (bus_wdata == C_EXIT) && rd_mode;
        end
      end
      if (bus_wr && bus_sel == S_AH) addr[AW-1:8] <= bus_wdata[AW-9:0];
      else if (bus_wr && bus_sel == S_AL) addr[7:0] <= bus_wdata[7:0];
      else if (rd_ok) addr <= addr + 1'b1;
      if (data_rd && !rd_ok) err <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_sel)
        S_AH:  bus_rdata = DW'(addr[AW-1:8]);
        S_AL:  bus_rdata = DW'(addr[7:0]);
        S_DAT: bus_rdata = rd_ok ? mem_rdata : '0;
        S_STA: bus_rdata = DW'({hold, rd_mode, wr_lock, rd_lock, err});
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module otp_dbg_port_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_sel,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic [AW-1:0] addr,
  input logic          hold,
  input logic          rd_mode,
  input logic          rd_lock,
  input logic          wr_lock,
  input logic          err
);
  logic drd;
  assign drd = bus_rd && bus_sel == 3'd4;

  AST_MODE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode |-> hold); // R4
  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    drd && rd_mode && !rd_lock |=> addr == $past(addr) + 1'b1); // R6
  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    drd && rd_lock |-> bus_rdata == '0); // R8
  AST_BLOCKED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    drd && !(rd_mode && !rd_lock) |=> $stable(addr) && err); // R10
  AST_RDLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(rd_lock)); // R9
  AST_WRLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(wr_lock)); // R9
endmodule

bind otp_dbg_port otp_dbg_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .addr(mem_addr), .hold(core_rst),
  .rd_mode(rd_mode), .rd_lock(rd_lock), .wr_lock(wr_lock), .err(err)
);

// File: tb/otp_dbg_port_tb.sv
module otp_dbg_port_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, core_rst;
  logic [2:0] bus_sel = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, mem_rdata, sec_byte = 8'hFF;
  logic [15:0] mem_addr;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata = fmem(mem_addr);

  otp_dbg_port u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .sec_byte(sec_byte),
    .core_rst(core_rst));

  function automatic logic [7:0] st(input logic hd, md, wl, rl, er);
    return {3'b0, hd, md, wl, rl, er};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); bus_sel = s; bus_rd = 1'b1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] sec);
    @(negedge clk); rst_n = 1'b0; sec_byte = sec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd_addr(output logic [15:0] a);
    logic [7:0] h, l;
    rd(3'd2, h); rd(3'd3, l); a = {h, l};
  endtask

  initial begin
    logic [7:0] v;
    logic [15:0] a;
    do_reset(8'hFF);
    rd(3'd5, v); chk("R1 status", v, 8'h00);
    rd_addr(a);  chk("R1 addr", a, 16'h0000);
    chk("R1 core_rst", core_rst, 1'b0);
    rd(3'd4, v); chk("R10 data no session", v, 8'h00);
    rd(3'd5, v); chk("R10 err", v, st(0,0,0,0,1));
    rd_addr(a);  chk("R10 addr still", a, 16'h0000);
    wr(3'd1, 8'h00);
    rd(3'd5, v); chk("R4 no hold ignored", v, st(0,0,0,0,1));
    wr(3'd0, 8'h04);
    chk("R2 core_rst", core_rst, 1'b1);
    rd(3'd5, v); chk("R2 status", v, st(1,0,0,0,1));
    wr(3'd0, 8'h00);
    rd(3'd5, v); chk("R3 lone zero keeps hold", v, st(1,0,0,0,1));
    wr(3'd1, 8'h00);
    rd(3'd5, v); chk("R4 session open err clear", v, st(1,1,0,0,0));
    wr(3'd2, 8'h12); wr(3'd3, 8'h34);
    rd_addr(a); chk("R11 readback", a, 16'h1234);
    for (int i = 0; i < 300; i++) begin
      rd(3'd4, v); chk("R6 seq data", v, fmem(16'h1234 + 16'(i)));
    end
    rd_addr(a); chk("R6 addr after sweep", a, 16'h1234 + 16'd300);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFE);
    for (int i = 0; i < 3; i++) begin
      rd(3'd4, v); chk("R6 wrap data", v, fmem(16'hFFFE + 16'(i)));
    end
    rd_addr(a); chk("R6 wrap addr", a, 16'h0001);
    wr(3'd1, 8'h40);
    rd(3'd5, v); chk("R5 lone 0x40 keeps session", v, st(1,1,0,0,0));
    rd(3'd4, v); chk("R5 data still served", v, fmem(16'h0001));
    wr(3'd1, 8'h40); wr(3'd1, 8'h00);
    rd(3'd5, v); chk("R5 session closed", v, st(1,0,0,0,0));
    rd(3'd4, v); chk("R10 closed data zero", v, 8'h00);
    rd(3'd5, v); chk("R10 closed err", v, st(1,0,0,0,1));
    rd_addr(a); chk("R10 closed addr still", a, 16'h0002);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h02); wr(3'd0, 8'h00);
    chk("R3 release core_rst", core_rst, 1'b0);
    rd(3'd5, v); chk("R3 release status", v, st(0,0,0,0,0));

    for (int s = 0; s < 256; s++) begin
      logic rl, wl;
      rl = (s[3:0] != 4'hF); wl = (s[7:4] != 4'hF);
      do_reset(8'(s));
      wr(3'd0, 8'h04); wr(3'd1, 8'h00);
      wr(3'd2, 8'h00); wr(3'd3, 8'h10);
      rd(3'd5, v); chk("R7 R8 lock bits", v, st(1,1,wl,rl,0));
      rd(3'd4, v); chk("R8 data", v, rl ? 8'h00 : fmem(16'h0010));
      rd(3'd5, v); chk("R8 err", v, st(1,1,wl,rl,rl));
      rd_addr(a); chk("R8 addr", a, rl ? 16'h0010 : 16'h0011);
    end

    do_reset(8'hFF);
    wr(3'd0, 8'h04); wr(3'd1, 8'h00);
    @(negedge clk); sec_byte = 8'hF0;
    @(negedge clk); sec_byte = 8'h0F;
    @(negedge clk); sec_byte = 8'hFF;
    rd(3'd5, v); chk("R9 locks kept", v, st(1,1,1,1,0));
    rd(3'd4, v); chk("R9 read still blocked", v, 8'h00);
    rd_addr(a); chk("R9 addr still", a, 16'h0000);
    do_reset(8'hFF);
    rd(3'd5, v); chk("R9 reset clears locks", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule